// File: doc/BRIEF.md
# I/O Port Permission Bitmap Checker

This block decides whether a port access of 1, 2 or 4 bytes at a 16-bit port address may proceed. It gets the attributes of the current task segment: present flag, 4-bit type, limit and base. It first checks that the segment is usable. Then it fetches the bitmap pointer from the task segment, fetches a 16-bit slice of the permission bitmap, and tests the bits that cover the accessed ports. The result is either allow, or a general-protection fault whose error code is always zero.

The surrounding pipeline decides when the check is needed, for example from the privilege level. It pulses `chk_start` and waits for the single-cycle `chk_done`. Both reads go through a simple request/acknowledge memory port. The request is held until the matching acknowledge arrives, and the data is valid in the acknowledge cycle.

Top module: `iopm_checker`

## Requirements
- R1: After reset, `chk_done`, `chk_allow`, `chk_fault` and `mem_req` are low.
- R2: The task segment qualifies only when `ts_present` is 1, `ts_type` equals 9 and `ts_limit` is at least 103. Otherwise the check faults without any memory read. `chk_done` rises in the cycle after the start cycle.
- R3: For a qualified segment, the first read is at address `ts_base + 0x66` and returns the 16-bit bitmap pointer.
- R4: The window offset is the bitmap pointer (zero-extended) plus `chk_port >> 3`. The second read is at `ts_base + offset`.
- R5: If offset + 1 is greater than `ts_limit`, the check faults after the first read and makes no second read. Offset + 1 equal to the limit is still accepted.
- R6: The 16-bit window is shifted right by `chk_port[2:0]`. The low N bits are tested, where N is the access size in bytes. Access is allowed only when all tested bits are zero, so an access may span into the second byte of the window.
- R7: `chk_size` encodes the byte count directly (1, 2 or 4). Any other value faults without a memory read, with the same timing as R2.
- R8: `chk_done` is high for exactly one cycle per accepted start. While it is high, exactly one of `chk_allow` and `chk_fault` is high. A fault always means a general-protection fault with error code zero.
- R9: Once raised, `mem_req` and `mem_addr` stay constant until `mem_ack` is seen.
- R10: `chk_start` is ignored while a check is in progress. Only the first request produces a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_start | input | 1 | Starts a check when the block is idle |
| chk_port | input | 16 | Port address of the access |
| chk_size | input | 3 | Access size in bytes (1, 2 or 4) |
| ts_present | input | 1 | Task segment present flag |
| ts_type | input | 4 | Task segment descriptor type |
| ts_limit | input | 32 | Task segment limit |
| ts_base | input | 32 | Task segment base address |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Read data |
| chk_done | output | 1 | Result valid, one cycle |
| chk_allow | output | 1 | Access permitted |
| chk_fault | output | 1 | General-protection fault, error code zero |

## Verification
The assertions assume that `mem_ack` comes only while a request is pending. They also assume that the task-segment inputs and the request fields stay steady from the start pulse until `chk_done`. The bench's memory model returns one acknowledge per request, after a latency of one to three cycles. The bench drives new attributes only between checks. It covers window positions where the tested bits cross the byte boundary of the window, and limits placed exactly at and one below the acceptance point.

// File: rtl/iopm_pkg.sv
package iopm_pkg;
  localparam logic [15:0] TS_MAP_PTR_OFS = 16'h0066;
  localparam int unsigned TS_MIN_LIMIT   = 103;
  localparam logic [3:0]  TS_TYPE_AVAIL32 = 4'd9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD_MAP = 2'd1,
    ST_RD_WIN = 2'd2,
    ST_RESP = 2'd3
  } iopm_state_e;

  function automatic logic size_valid(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction
endpackage

// File: rtl/iopm_ts_qual.sv
module iopm_ts_qual #(
  parameter int ADDR_W = 32
) (
  input  logic              present,
  input  logic [3:0]        seg_type,
  input  logic [ADDR_W-1:0] limit,
  output logic              usable
);
  import iopm_pkg::*;
  localparam logic [ADDR_W-1:0] MIN_LIM = ADDR_W'(TS_MIN_LIMIT);

  always_comb begin
    usable = present && (seg_type == TS_TYPE_AVAIL32) && (limit >= MIN_LIM);
  end
endmodule

// File: rtl/iopm_win_eval.sv
module iopm_win_eval #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] window,
  input  logic [2:0]       bit_sel,
  input  logic [2:0]       size,
  output logic             permit
);
  import iopm_pkg::*;
  localparam int MASK_W = 4;

  logic [WIN_W-1:0]  shifted;
  logic [MASK_W-1:0] mask;

  always_comb begin
    shifted = window >> bit_sel;
    case (size)
      3'd1:    mask = 4'b0001;
      3'd2:    mask = 4'b0011;
      3'd4:    mask = 4'b1111;
      default: mask = 4'b0000;
    endcase
    permit = size_valid(size) && ((shifted[MASK_W-1:0] & mask) == '0);
  end

  // R6
  low_bit_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window[bit_sel] |-> !permit);
endmodule

// File: rtl/iopm_checker.sv
module iopm_checker #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int WIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_start,
  input  logic [PORT_W-1:0] chk_port,
  input  logic [2:0]        chk_size,
  input  logic              ts_present,
  input  logic [3:0]        ts_type,
  input  logic [ADDR_W-1:0] ts_limit,
  input  logic [ADDR_W-1:0] ts_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WIN_W-1:0]  mem_rdata,
  output logic              chk_done,
  output logic              chk_allow,
  output logic              chk_fault
);
  import iopm_pkg::*;
  localparam int BYTE_SEL_W = PORT_W - 3;

  iopm_state_e       state_q, state_d;
  logic [PORT_W-1:0] port_q;
  logic [2:0]        size_q;
  logic [ADDR_W-1:0] base_q, limit_q, wofs_q, wofs_d;
  logic              res_q, res_d;
  logic              cap_en;
  logic              qual_ok, win_ok;
  logic [ADDR_W-1:0] map_sum;

  iopm_ts_qual #(.ADDR_W(ADDR_W)) u_qual (
    .present(ts_present), .seg_type(ts_type), .limit(ts_limit), .usable(qual_ok)
  );

  iopm_win_eval #(.WIN_W(WIN_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .window(mem_rdata), .bit_sel(port_q[2:0]),
    .size(size_q), .permit(win_ok)
  );

  assign map_sum = ADDR_W'(mem_rdata) + ADDR_W'(port_q[PORT_W-1 -: BYTE_SEL_W]);

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    wofs_d  = wofs_q;
    cap_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (chk_start) begin
          cap_en = 1'b1;
          if (qual_ok && size_valid(chk_size)) begin
            state_d = ST_RD_MAP;
          end else begin
            res_d   = 1'b0;
            state_d = ST_RESP;
          end
        end
      end
      ST_RD_MAP: begin
        if (mem_ack) begin
          wofs_d = map_sum;
          if ((map_sum + ADDR_W'(1)) > limit_q) begin
            res_d   = 1'b0;
            state_d = ST_RESP;
          end else begin
            state_d = ST_RD_WIN;
          end
        end
      end
      ST_RD_WIN: begin
        if (mem_ack) begin
          res_d   = win_ok;
          state_d = ST_RESP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= 1'b0;
      wofs_q  <= '0;
      port_q  <= '0;
      size_q  <= '0;
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      wofs_q  <= wofs_d;
      if (cap_en) begin
        port_q  <= chk_port;
        size_q  <= chk_size;
        base_q  <= ts_base;
        limit_q <= ts_limit;
      end
    end
  end

  always_comb begin
    mem_req   = (state_q == ST_RD_MAP) || (state_q == ST_RD_WIN);
    mem_addr  = base_q + ((state_q == ST_RD_WIN) ? wofs_q : ADDR_W'(TS_MAP_PTR_OFS));
    chk_done  = (state_q == ST_RESP);
    chk_allow = chk_done && res_q;
    chk_fault = chk_done && !res_q;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |=> !chk_done);

  // R8
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> $countones({chk_allow, chk_fault}) == 1);

  // R2
  no_read_on_bad_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && chk_start && !qual_ok) |=> (!mem_req && chk_fault));

  // R5
  win_in_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_WIN) |-> ((wofs_q + ADDR_W'(1)) <= limit_q));
endmodule

// File: tb/sim_iopm_checker.sv
module sim_iopm_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_start = 1'b0;
  logic [15:0] chk_port = '0;
  logic [2:0]  chk_size = 3'd1;
  logic        ts_present = 1'b0;
  logic [3:0]  ts_type = '0;
  logic [31:0] ts_limit = '0;
  logic [31:0] ts_base = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        chk_done, chk_allow, chk_fault;

  int checks = 0;
  int failures = 0;
  int nreads = 0;
  int ndone = 0;
  int lat = 1;
  int cnt = 0;
  logic [31:0] rd_addr0, rd_addr1;
  logic [15:0] m_map, m_win;
  logic [31:0] m_win_addr;

  always #2 clk = ~clk;

  iopm_checker u0 (
    .clk(clk), .rst_n(rst_n), .chk_start(chk_start), .chk_port(chk_port),
    .chk_size(chk_size), .ts_present(ts_present), .ts_type(ts_type),
    .ts_limit(ts_limit), .ts_base(ts_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .chk_done(chk_done),
    .chk_allow(chk_allow), .chk_fault(chk_fault)
  );

  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        cnt <= 0;
        mem_ack <= 1'b1;
        if (nreads == 0) rd_addr0 <= mem_addr;
        else rd_addr1 <= mem_addr;
        nreads <= nreads + 1;
        if (mem_addr == ts_base + 32'h66) mem_rdata <= m_map;
        else if (mem_addr == m_win_addr) mem_rdata <= m_win;
        else mem_rdata <= 16'hFFFF;
      end else begin
        cnt <= cnt + 1;
      end
    end
    if (chk_done) ndone <= ndone + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [15:0] port, input logic [2:0] size,
                     input logic pres, input logic [3:0] typ, input logic [31:0] lim,
                     input logic [31:0] base, input logic [15:0] map, input logic [15:0] win,
                     input logic exp_allow, input int exp_reads);
    int waited = 0;
    @(negedge clk);
    chk_port = port; chk_size = size; ts_present = pres; ts_type = typ;
    ts_limit = lim; ts_base = base; m_map = map; m_win = win;
    m_win_addr = base + 32'(map) + 32'(port >> 3);
    nreads = 0;
    chk_start = 1'b1;
    @(negedge clk);
    chk_start = 1'b0;
    while (!chk_done && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    check({req, " done seen"}, 32'(chk_done), 1);
    check({req, " allow"}, 32'(chk_allow), 32'(exp_allow));
    check({req, " fault"}, 32'(chk_fault), 32'(!exp_allow));
    check({req, " reads"}, nreads, exp_reads);
    if (exp_reads >= 1) check("R3 map addr", rd_addr0, base + 32'h66);
    if (exp_reads == 2) check("R4 win addr", rd_addr1, m_win_addr);
    if (exp_reads == 0) check({req, " immediate done"}, waited, 0);
    @(negedge clk);
    check("R8 done one cycle", 32'(chk_done), 0);
  endtask

  task automatic test_busy();
    int d0;
    @(negedge clk);
    chk_port = 16'h0010; chk_size = 3'd1; ts_present = 1; ts_type = 4'd9;
    ts_limit = 32'h200; ts_base = 32'h4000; m_map = 16'h68; m_win = 16'h0000;
    m_win_addr = 32'h4000 + 32'h68 + 32'h2;
    nreads = 0; lat = 3; d0 = ndone;
    chk_start = 1'b1;
    @(negedge clk);
    chk_port = 16'h0000; ts_present = 0;
    repeat (3) @(negedge clk);
    chk_start = 1'b0;
    repeat (15) @(negedge clk);
    check("R10 one done", ndone - d0, 1);
    check("R10 both reads of first request", nreads, 2);
    check("R10 win addr of first request", rd_addr1, m_win_addr);
    lat = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", 32'(chk_done), 0);
    check("R1 allow", 32'(chk_allow), 0);
    check("R1 fault", 32'(chk_fault), 0);
    check("R1 req", 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 basic allow / deny
    run("R6 allow byte", 16'h03F8, 3'd1, 1, 4'd9, 32'h2067, 32'h1000, 16'h68, 16'h0000, 1, 2);
    run("R6 deny byte", 16'h03F8, 3'd1, 1, 4'd9, 32'h2067, 32'h1000, 16'h68, 16'h0001, 0, 2);
    lat = 2;
    // R6 span: port 0x3FE size 4 tests window bits 6..9
    run("R6 span deny", 16'h03FE, 3'd4, 1, 4'd9, 32'h2067, 32'h1000, 16'h68, 16'h0100, 0, 2);
    run("R6 span allow", 16'h03FE, 3'd4, 1, 4'd9, 32'h2067, 32'h1000, 16'h68, 16'hFC3F, 1, 2);
    lat = 0;
    run("R6 word edge", 16'h0005, 3'd2, 1, 4'd9, 32'h2067, 32'h1000, 16'h68, 16'hFF9F, 1, 2);
    run("R6 word deny", 16'h0005, 3'd2, 1, 4'd9, 32'h2067, 32'h1000, 16'h68, 16'h0040, 0, 2);
    // R2 qualification
    run("R2 not present", 16'h0000, 3'd1, 0, 4'd9, 32'h2067, 32'h1000, 16'h68, 16'h0000, 0, 0);
    run("R2 busy type", 16'h0000, 3'd1, 1, 4'd11, 32'h2067, 32'h1000, 16'h68, 16'h0000, 0, 0);
    run("R2 limit 102", 16'h0000, 3'd1, 1, 4'd9, 32'd102, 32'h1000, 16'h68, 16'h0000, 0, 0);
    run("R2 limit 103", 16'h0000, 3'd1, 1, 4'd9, 32'd103, 32'h1000, 16'h66, 16'h0000, 1, 2);
    // R5 limit boundary: offset 0x68
    run("R5 at limit", 16'h0000, 3'd1, 1, 4'd9, 32'h69, 32'h800, 16'h68, 16'h0000, 1, 2);
    run("R5 over limit", 16'h0000, 3'd1, 1, 4'd9, 32'h68, 32'h800, 16'h68, 16'h0000, 0, 1);
    run("R5 port shift over", 16'h0008, 3'd1, 1, 4'd9, 32'h69, 32'h800, 16'h68, 16'h0000, 0, 1);
    // R7 invalid sizes
    run("R7 size 3", 16'h0000, 3'd3, 1, 4'd9, 32'h2067, 32'h1000, 16'h68, 16'h0000, 0, 0);
    run("R7 size 0", 16'h0000, 3'd0, 1, 4'd9, 32'h2067, 32'h1000, 16'h68, 16'h0000, 0, 0);
    test_busy();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule